// File: doc/BRIEF.md
# Stereo Sample Transmit Buffer with Word Packing

This block sits between a register bus and the serial frame generator of an audio link. Software writes audio words into it. Every word becomes one or two stored entries, and every entry is a left-justified 20-bit sample with zeros below the sample's own bits. A two-bit width selector gives the sample width (12, 16, 18 or 20 bits). A packing control lets one bus word carry two 16-bit halves instead of one sample.

Stored entries leave as stereo pairs through a valid/ready port. The older entry of each pair is the left channel. Output is gated by a transmit enable and by two slot enables. A burst of pairs starts only once the buffer is at least half full. It then continues while at least two entries remain. Four sticky status flags report empty, half-empty, full and underrun. The depth is a power-of-two parameter, 8 by default.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset, stEmpty=1, stHalfEmpty=1, stFull=0, stUnderrun=0 and outValid=0.
- R2: With packing off, a write stores one entry: wrData[19:0] shifted left and truncated to 20 bits. The shift depends on cfgSize: 0 gives 16-bit samples (shift 4), 1 gives 18-bit (shift 2), 2 gives 20-bit (shift 0) and 3 gives 12-bit (shift 8).
- R3: With packing on and cfgSize 0 or 3, a write stores two entries. wrData[15:0] is stored first and wrData[31:16] second. Each half is shifted left by 4 (cfgSize 0) or by 8 (cfgSize 3), and only its low 20 bits are kept.
- R4: When cfgSize is 1 or 2, cfgCompact is ignored and each write stores one entry as in R2.
- R5: A single-entry write is accepted only when the level is below DEPTH. A two-entry write is accepted only when the level plus 2 is strictly below DEPTH. A refused write changes neither the stored data nor the level.
- R6: outValid is 0 unless cfgTxEnable=1 and cfgSlotEnable is nonzero. A burst starts only when the level is at least DEPTH/2.
- R7: outLeft is the oldest entry and outRight the next one. One pair is removed on each cycle with outValid and outReady both high. While outReady is low the pair holds. Once started, a burst continues while two or more entries remain, then stops.
- R8: An accepted write clears stEmpty and stUnderrun. It clears stHalfEmpty if the resulting level is at least DEPTH/2. It sets stFull if the resulting level reaches DEPTH.
- R9: A removed pair clears stFull. It sets stHalfEmpty if the new level is at most DEPTH/2. It sets both stEmpty and stUnderrun if the new level is 0.
- R10: When a write and a pair removal fall in the same cycle, the write is judged against the level before the removal. Where the two disagree on a flag, the removal's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgTxEnable | input | 1 | Transmit enable |
| cfgSlotEnable | input | 2 | Enables for the two audio slots |
| cfgCompact | input | 1 | Two samples per write when the width allows it |
| cfgSize | input | 2 | Sample width selector (see R2) |
| wrValid | input | 1 | Write strobe |
| wrData | input | 32 | Written audio word |
| outValid | output | 1 | A stereo pair is offered |
| outReady | input | 1 | Sink accepts the pair |
| outLeft | output | 20 | Left sample of the offered pair |
| outRight | output | 20 | Right sample of the offered pair |
| stEmpty | output | 1 | Empty flag |
| stHalfEmpty | output | 1 | Half-empty flag |
| stFull | output | 1 | Full flag |
| stUnderrun | output | 1 | Underrun flag |

## Verification
A bus write and the removal of a pair can land on the same clock edge. Both then move the level and the flags. The bench provokes this twice. First it raises outReady in the same cycle as a write while four entries are held. The write must be kept, and the half-empty flag must end set because the removal's update wins. Second, it does the same at full level. The write must be refused even though space frees up on that edge, and the full flag must clear. The later pairs prove which writes were kept.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int SAMPLE_W = 20;
  localparam int BUS_W    = 32;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ18 = 2'd1,
    SZ20 = 2'd2,
    SZ12 = 2'd3
  } sample_size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pushOne;
    logic pushTwo;
    logic popPair;
  } fifo_strobe_t;
endpackage

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         txEnable,
  input  logic [1:0]   slotEnable,
  input  logic         compactReq,
  input  logic [1:0]   sizeSel,
  input  logic         wrValid,
  input  logic         outReady,
  output logic         outValid,
  output fifo_strobe_t strobe,
  output logic         flagEmpty,
  output logic         flagHalfEmpty,
  output logic         flagFull,
  output logic         flagUnderrun
);
  localparam int LVL_W = $clog2(DEPTH) + 1;
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] HALF_L  = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] TWO_L   = LVL_W'(2);

  logic [LVL_W-1:0] level, levelWr, levelNext;
  logic             drainActive, gateOn, compactEff, popNow, pushAny;

  always_comb begin
    compactEff = compactReq && ((sizeSel == SZ16) || (sizeSel == SZ12));
    gateOn     = txEnable && (|slotEnable);
    outValid   = gateOn && (level >= TWO_L) && (drainActive || (level >= HALF_L));
    popNow     = outValid && outReady;

    strobe.pushTwo = wrValid && compactEff && ((level + TWO_L) < DEPTH_L);
    strobe.pushOne = wrValid && !compactEff && (level < DEPTH_L);
    strobe.popPair = popNow;
    pushAny        = strobe.pushOne || strobe.pushTwo;

    levelWr = level;
    if (strobe.pushTwo) levelWr = level + TWO_L;
    else if (strobe.pushOne) levelWr = level + LVL_W'(1);
    levelNext = popNow ? (levelWr - TWO_L) : levelWr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level       <= '0;
      drainActive <= 1'b0;
    end else begin
      level       <= levelNext;
      drainActive <= outValid && (levelNext >= TWO_L);
    end
  end

  // write-side updates first, removal-side updates last so they win
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagEmpty     <= 1'b1;
      flagHalfEmpty <= 1'b1;
      flagFull      <= 1'b0;
      flagUnderrun  <= 1'b0;
    end else begin
      if (pushAny) begin
        flagEmpty    <= 1'b0;
        flagUnderrun <= 1'b0;
        if (levelWr >= HALF_L)  flagHalfEmpty <= 1'b0;
        if (levelWr >= DEPTH_L) flagFull      <= 1'b1;
      end
      if (popNow) begin
        flagFull <= 1'b0;
        if (levelNext <= HALF_L) flagHalfEmpty <= 1'b1;
        if (levelNext == '0) begin
          flagEmpty    <= 1'b1;
          flagUnderrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audio_tx_datapath.sv
module audio_tx_datapath
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fifo_strobe_t        strobe,
  input  logic [1:0]          sizeSel,
  input  logic [BUS_W-1:0]    wrData,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [SAMPLE_W-1:0] padSingle, padLow, padHigh, halfLow, halfHigh;
  logic [3:0]          shSingle, shPair;

  always_comb begin
    unique case (sample_size_e'(sizeSel))
      SZ16:    shSingle = 4'd4;
      SZ18:    shSingle = 4'd2;
      SZ20:    shSingle = 4'd0;
      default: shSingle = 4'd8;
    endcase
    shPair    = (sizeSel == SZ12) ? 4'd8 : 4'd4;
    padSingle = wrData[SAMPLE_W-1:0] << shSingle;
    halfLow   = {4'b0, wrData[15:0]};
    halfHigh  = {4'b0, wrData[31:16]};
    padLow    = halfLow << shPair;
    padHigh   = halfHigh << shPair;
  end

  always_ff @(posedge clk) begin
    if (strobe.pushOne) begin
      mem[wrPtr] <= padSingle;
    end else if (strobe.pushTwo) begin
      mem[wrPtr]               <= padLow;
      mem[wrPtr + PTR_W'(1)]   <= padHigh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.pushOne)      wrPtr <= wrPtr + PTR_W'(1);
      else if (strobe.pushTwo) wrPtr <= wrPtr + PTR_W'(2);
      if (strobe.popPair)      rdPtr <= rdPtr + PTR_W'(2);
    end
  end

  assign outLeft  = mem[rdPtr];
  assign outRight = mem[rdPtr + PTR_W'(1)];
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import audio_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgTxEnable,
  input  logic [1:0]          cfgSlotEnable,
  input  logic                cfgCompact,
  input  logic [1:0]          cfgSize,
  input  logic                wrValid,
  input  logic [BUS_W-1:0]    wrData,
  output logic                outValid,
  input  logic                outReady,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight,
  output logic                stEmpty,
  output logic                stHalfEmpty,
  output logic                stFull,
  output logic                stUnderrun
);
  fifo_strobe_t strobe;

  audio_tx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .txEnable(cfgTxEnable), .slotEnable(cfgSlotEnable),
    .compactReq(cfgCompact), .sizeSel(cfgSize),
    .wrValid(wrValid), .outReady(outReady), .outValid(outValid),
    .strobe(strobe),
    .flagEmpty(stEmpty), .flagHalfEmpty(stHalfEmpty),
    .flagFull(stFull), .flagUnderrun(stUnderrun)
  );

  audio_tx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .sizeSel(cfgSize), .wrData(wrData),
    .outLeft(outLeft), .outRight(outRight)
  );
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk
  import audio_tx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cfgTxEnable,
  input logic [1:0]          cfgSlotEnable,
  input logic                wrValid,
  input logic                outValid,
  input logic                outReady,
  input logic [SAMPLE_W-1:0] outLeft,
  input logic [SAMPLE_W-1:0] outRight,
  input logic                stEmpty,
  input logic                stHalfEmpty,
  input logic                stFull,
  input logic                stUnderrun
);
  // R6: nothing offered without the gate
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (cfgTxEnable && (|cfgSlotEnable)));

  // R7: a stalled pair stays offered and unchanged while the gate holds
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) ##1 (cfgTxEnable && (|cfgSlotEnable))
      |-> (outValid && $stable(outLeft) && $stable(outRight)));

  // R9: a removal always clears full
  p_full_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady) |=> !stFull);

  // R9: an empty buffer offers nothing
  p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stEmpty |-> !outValid);

  // R8: full excludes empty and half-empty
  p_full_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stFull |-> (!stEmpty && !stHalfEmpty));

  // R9: underrun only alongside empty
  p_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stUnderrun |-> stEmpty);

  // R5: a write never lands while the buffer is full and idle
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stFull && wrValid && !outValid) |=> stFull);
endmodule

bind audio_tx_fifo audio_tx_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfgTxEnable(cfgTxEnable),
  .cfgSlotEnable(cfgSlotEnable), .wrValid(wrValid),
  .outValid(outValid), .outReady(outReady),
  .outLeft(outLeft), .outRight(outRight),
  .stEmpty(stEmpty), .stHalfEmpty(stHalfEmpty),
  .stFull(stFull), .stUnderrun(stUnderrun)
);

// File: tb/audio_tx_fifo_tb.sv
module audio_tx_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgTxEnable = 1'b0;
  logic [1:0]  cfgSlotEnable = 2'b00;
  logic        cfgCompact = 1'b0;
  logic [1:0]  cfgSize = 2'd0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        outReady = 1'b0;
  logic        outValid;
  logic [19:0] outLeft, outRight;
  logic        stEmpty, stHalfEmpty, stFull, stUnderrun;

  int nVec = 0;
  int nBad = 0;

  audio_tx_fifo #(.DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgTxEnable(cfgTxEnable),
    .cfgSlotEnable(cfgSlotEnable), .cfgCompact(cfgCompact), .cfgSize(cfgSize),
    .wrValid(wrValid), .wrData(wrData), .outValid(outValid), .outReady(outReady),
    .outLeft(outLeft), .outRight(outRight), .stEmpty(stEmpty),
    .stHalfEmpty(stHalfEmpty), .stFull(stFull), .stUnderrun(stUnderrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock edge; inputs are driven and outputs sampled at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sz, logic cmp, logic [31:0] d);
    cfgSize = sz; cfgCompact = cmp; wrValid = 1'b1; wrData = d;
    step();
    wrValid = 1'b0;
  endtask

  task automatic popPair(string req, logic [19:0] l, logic [19:0] r);
    chk({req, " valid"}, 32'(outValid), 32'd1);
    chk({req, " left"}, 32'(outLeft), 32'(l));
    chk({req, " right"}, 32'(outRight), 32'(r));
    outReady = 1'b1;
    step();
    outReady = 1'b0;
  endtask

  task automatic flags(string req, logic e, logic h, logic f, logic u);
    chk({req, " flags"}, {28'd0, stEmpty, stHalfEmpty, stFull, stUnderrun},
        {28'd0, e, h, f, u});
  endtask

  task automatic gate(logic en, logic [1:0] sl);
    cfgTxEnable = en; cfgSlotEnable = sl;
  endtask

  task automatic doReset();
    rst_n = 1'b0; gate(1'b0, 2'b00); wrValid = 1'b0; outReady = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic test_reset();
    doReset();
    flags("R1", 1, 1, 0, 0);
    chk("R1 valid", 32'(outValid), 0);
  endtask

  task automatic test_single();
    doReset();
    wr(2'd0, 0, 32'hFFFF_1234);
    wr(2'd1, 0, 32'h0003_ABCD);
    wr(2'd2, 0, 32'hABC9_8765);
    flags("R8 level3", 0, 1, 0, 0);
    wr(2'd3, 0, 32'h0000_0FED);
    flags("R8 level4", 0, 0, 0, 0);
    wr(2'd3, 0, 32'h1234_5A5A);
    wr(2'd0, 0, 32'h0000_8001);
    wr(2'd2, 0, 32'h000F_FFFF);
    wr(2'd1, 0, 32'h0000_0001);
    flags("R8 full", 0, 0, 1, 0);
    wr(2'd1, 0, 32'h0000_0777);        // R5: refused at full
    gate(1'b1, 2'b01);
    step();
    chk("R7 stall left", 32'(outLeft), 32'h12340);
    step();
    popPair("R2 pair1", 20'h12340, 20'hEAF34);
    flags("R9 full cleared", 0, 0, 0, 0);
    popPair("R2 pair2", 20'h98765, 20'hFED00);
    flags("R9 half set", 0, 1, 0, 0);
    popPair("R2 pair3", 20'hA5A00, 20'h80010);
    popPair("R2 pair4", 20'hFFFFF, 20'h00004);
    chk("R5 dropped word absent", 32'(outValid), 0);
    flags("R9 drained", 1, 1, 0, 1);
    gate(1'b0, 2'b00);
  endtask

  task automatic test_compact();
    doReset();
    wr(2'd0, 1, 32'hBEEF_1234);
    wr(2'd3, 1, 32'hFABC_0123);
    wr(2'd0, 1, 32'h0001_0002);
    wr(2'd0, 1, 32'h5555_6666);        // R5: 6+2 not below 8
    flags("R5 level6", 0, 0, 0, 0);
    gate(1'b1, 2'b10);
    step();
    popPair("R3 pair1", 20'h12340, 20'hBEEF0);
    popPair("R3 pair2", 20'h12300, 20'hABC00);
    popPair("R3 pair3", 20'h00020, 20'h00010);
    chk("R5 compact refused", 32'(outValid), 0);
    flags("R9 compact drained", 1, 1, 0, 1);
    gate(1'b0, 2'b00);
  endtask

  task automatic test_forced();
    doReset();
    wr(2'd2, 1, 32'h0001_2345);
    wr(2'd1, 1, 32'h0000_0100);
    wr(2'd2, 0, 32'h0001_1111);
    wr(2'd2, 0, 32'h0002_2222);
    gate(1'b1, 2'b01);
    step();
    popPair("R4 pair1", 20'h12345, 20'h00400);
    popPair("R4 pair2", 20'h11111, 20'h22222);
    chk("R4 no extra", 32'(outValid), 0);
    gate(1'b0, 2'b00);
  endtask

  task automatic test_gate();
    doReset();
    gate(1'b1, 2'b10);
    wr(2'd2, 0, 32'h1); wr(2'd2, 0, 32'h2); wr(2'd2, 0, 32'h3);
    chk("R6 below half", 32'(outValid), 0);
    wr(2'd2, 0, 32'h4);
    popPair("R6 threshold pair1", 20'h1, 20'h2);
    popPair("R7 burst pair2", 20'h3, 20'h4);
    chk("R7 burst end", 32'(outValid), 0);
    gate(1'b1, 2'b00);
    for (int i = 1; i <= 5; i++) wr(2'd2, 0, 32'h10 + 32'(i));
    chk("R6 no slots", 32'(outValid), 0);
    gate(1'b0, 2'b11);
    step();
    chk("R6 tx off", 32'(outValid), 0);
    gate(1'b1, 2'b01);
    step();
    popPair("R7 odd pair1", 20'h11, 20'h12);
    popPair("R7 odd pair2", 20'h13, 20'h14);
    chk("R7 single left", 32'(outValid), 0);
    flags("R9 one left", 0, 1, 0, 0);
    wr(2'd2, 0, 32'h16);
    chk("R7 restart needs half", 32'(outValid), 0);
    wr(2'd2, 0, 32'h17); wr(2'd2, 0, 32'h18);
    popPair("R7 restart pair1", 20'h15, 20'h16);
    popPair("R7 restart pair2", 20'h17, 20'h18);
    gate(1'b0, 2'b00);
  endtask

  task automatic test_concurrent();
    doReset();
    gate(1'b1, 2'b01);
    for (int i = 1; i <= 4; i++) wr(2'd2, 0, 32'hA0000 + 32'(i));
    chk("R10 offered", 32'(outValid), 1);
    chk("R10 left", 32'(outLeft), 32'hA0001);
    outReady = 1'b1;
    wr(2'd2, 0, 32'hA0005);            // write and removal on one edge
    outReady = 1'b0;
    flags("R10 removal wins", 0, 1, 0, 0);
    popPair("R10 pair2", 20'hA0003, 20'hA0004);
    chk("R10 level1", 32'(outValid), 0);
    wr(2'd2, 0, 32'hA0006); wr(2'd2, 0, 32'hA0007); wr(2'd2, 0, 32'hA0008);
    popPair("R10 write kept", 20'hA0005, 20'hA0006);
    popPair("R10 pair4", 20'hA0007, 20'hA0008);
    gate(1'b0, 2'b00);
    for (int i = 1; i <= 8; i++) wr(2'd2, 0, 32'hB0000 + 32'(i));
    flags("R10 full", 0, 0, 1, 0);
    gate(1'b1, 2'b01);
    outReady = 1'b1;
    wr(2'd2, 0, 32'hB0009);            // judged against full level
    outReady = 1'b0;
    flags("R10 full cleared", 0, 0, 0, 0);
    popPair("R10 f2", 20'hB0003, 20'hB0004);
    popPair("R10 f3", 20'hB0005, 20'hB0006);
    popPair("R10 f4", 20'hB0007, 20'hB0008);
    chk("R10 full write refused", 32'(outValid), 0);
    flags("R10 final", 1, 1, 0, 1);
    gate(1'b0, 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nVec++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_single();
    test_compact();
    test_forced();
    test_gate();
    test_concurrent();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule